// File: doc/BRIEF.md
# Dual-Bus Credibility Tracker and Remapper

This block shares two memory buses between two hardware threads and keeps running after one bus fails permanently. Every bus carries its own credibility score, kept apart from any per-thread score. The block remembers which bus each thread was last granted. When an error strobe arrives for a thread, the block charges that error to the bus the thread was last using, and lowers that bus's score by one.

A bus whose score reaches zero is retired. From then on, both threads are steered to the surviving bus, which alternates its grants between them. A configuration input sets whether one or two buses are fitted. When no bus is left, a fault output rises and no further grants are issued.

Each cycle, the outputs give a grant per thread, the bus index each thread is steered to, and the availability of each bus.

Top module: `bus_cred_remap`

## Requirements
- R1: After reset both scores hold 4; busAvail[0] is 1, busAvail[1] equals dualBusCfg, and noBusFault is 0.
- R2: With both buses available, thread t is steered to bus t (busSel = 2'b10, bit t is the bus index of thread t), and grant equals threadReq.
- R3: With dualBusCfg = 0, bus 1 is never available, and both threads are steered to bus 0.
- R4: An accepted error lowers the blamed bus's score by one. The fourth such error retires the bus, so its busAvail bit is 0 from the next cycle on and never returns before reset.
- R5: The blamed bus is the stored bus of errThread. That stored bus is the bus the thread was last granted on, or bus t after reset. An error in the same cycle as a grant uses the map as it stood before that grant.
- R6: With exactly one bus available, both threads are steered to it. When both request, the grant alternates, starting with thread 0 after reset. A shared-bus grant to thread g makes the other thread favoured next.
- R7: An error whose blamed bus is unavailable is ignored: no score changes.
- R8: With no bus available, noBusFault is 1 and grant is 0.
- R9: A grant goes only to a requesting thread, and a single shared bus grants at most one thread per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dualBusCfg | input | 1 | 1 when two buses are fitted |
| threadReq | input | 2 | Per-thread access request |
| errValid | input | 1 | Error strobe |
| errThread | input | 1 | Thread the error belongs to |
| grant | output | 2 | Per-thread grant this cycle |
| busSel | output | 2 | Bit t is the bus index for thread t |
| busAvail | output | 2 | Per-bus availability |
| noBusFault | output | 1 | No bus left |

## Verification
Two functions can fall in the same cycle: an error charged to a thread's stored bus, and a grant that moves that thread onto another bus. The bench provokes this after bus 0 retires. It raises an error for thread 0 while thread 0 has not yet been granted on bus 1, and later raises one in the very cycle thread 0 is granted on bus 1. The first error must be ignored and the second must not lower bus 1. This is judged by the cycle in which bus 1 later retires, and by the noBusFault flag.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int NUM_BUS = 2;
  localparam int NUM_THR = 2;

  typedef struct packed {
    logic [NUM_BUS-1:0] decBus;
    logic [NUM_THR-1:0] mapWr;
    logic [NUM_THR-1:0] mapVal;
  } bcr_strobe_t;
endpackage

// File: rtl/bcr_datapath.sv
module bcr_datapath
  import bcr_pkg::*;
#(
  parameter int CRED_W    = 3,
  parameter int CRED_INIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bcr_strobe_t         strobe,
  output logic [NUM_BUS-1:0]  credLive,
  output logic [NUM_THR-1:0]  mapBus
);
  localparam logic [CRED_W-1:0] INIT_VAL = CRED_W'(CRED_INIT);

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_cred
    logic [CRED_W-1:0] credCnt;
    always_ff @(posedge clk) begin
      if (!rst_n) credCnt <= INIT_VAL;
      else if (strobe.decBus[b] && credCnt != '0) credCnt <= credCnt - 1'b1;
    end
    assign credLive[b] = (credCnt != '0);
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rst_n) mapBus[t] <= 1'(t);
      else if (strobe.mapWr[t]) mapBus[t] <= strobe.mapVal[t];
    end
  end
endmodule

// File: rtl/bcr_ctrl.sv
module bcr_ctrl
  import bcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dualBusCfg,
  input  logic [NUM_THR-1:0] threadReq,
  input  logic               errValid,
  input  logic               errThread,
  input  logic [NUM_BUS-1:0] credLive,
  input  logic [NUM_THR-1:0] mapBus,
  output bcr_strobe_t        strobe,
  output logic [NUM_THR-1:0] grant,
  output logic [NUM_THR-1:0] busSel,
  output logic [NUM_BUS-1:0] busAvail,
  output logic               noBusFault
);
  logic rrPtr;
  logic shared;
  logic blamedBus;

  always_comb begin
    busAvail[0] = credLive[0];
    busAvail[1] = credLive[1] & dualBusCfg;
    shared      = 1'b0;
    busSel      = '0;
    grant       = '0;
    noBusFault  = 1'b0;
    case (busAvail)
      2'b11: begin
        busSel = 2'b10;
        grant  = threadReq;
      end
      2'b01, 2'b10: begin
        shared = 1'b1;
        busSel = {NUM_THR{busAvail[1]}};
        if (threadReq == 2'b11) grant = rrPtr ? 2'b10 : 2'b01;
        else                    grant = threadReq;
      end
      default: noBusFault = 1'b1;
    endcase

    blamedBus            = mapBus[errThread];
    strobe.decBus        = '0;
    strobe.decBus[blamedBus] = errValid & busAvail[blamedBus];
    strobe.mapWr         = grant;
    strobe.mapVal        = busSel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rrPtr <= 1'b0;
    else if (shared && grant != '0) rrPtr <= grant[0];
  end
endmodule

// File: rtl/bus_cred_remap.sv
module bus_cred_remap
  import bcr_pkg::*;
#(
  parameter int CRED_W    = 3,
  parameter int CRED_INIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dualBusCfg,
  input  logic [1:0] threadReq,
  input  logic       errValid,
  input  logic       errThread,
  output logic [1:0] grant,
  output logic [1:0] busSel,
  output logic [1:0] busAvail,
  output logic       noBusFault
);
  bcr_strobe_t        strobe;
  logic [NUM_BUS-1:0] credLive;
  logic [NUM_THR-1:0] mapBus;

  bcr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .dualBusCfg(dualBusCfg), .threadReq(threadReq),
    .errValid(errValid), .errThread(errThread), .credLive(credLive),
    .mapBus(mapBus), .strobe(strobe), .grant(grant), .busSel(busSel),
    .busAvail(busAvail), .noBusFault(noBusFault)
  );

  bcr_datapath #(.CRED_W(CRED_W), .CRED_INIT(CRED_INIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .credLive(credLive), .mapBus(mapBus)
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       dualBusCfg,
  input logic [1:0] threadReq,
  input logic       errValid,
  input logic [1:0] grant,
  input logic [1:0] busSel,
  input logic [1:0] busAvail,
  input logic       noBusFault
);
  assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~threadReq) == 2'b00);
  assert_shared_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(busAvail) == 1) |-> $onehot0(grant));
  assert_split_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busAvail == 2'b11) |-> (busSel == 2'b10 && grant == threadReq));
  assert_steer_bus0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busAvail == 2'b01) |-> (busSel == 2'b00));
  assert_steer_bus1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busAvail == 2'b10) |-> (busSel == 2'b11));
  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(busAvail) == 1 && threadReq == 2'b11)
      |=> (!($countones(busAvail) == 1 && threadReq == 2'b11) || grant != $past(grant)));
  assert_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    noBusFault |-> (grant == 2'b00 && busAvail == 2'b00));
  assert_bus0_stays_retired_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busAvail[0] |=> !busAvail[0]);
  assert_bus1_stays_retired_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busAvail[1] && dualBusCfg) |=> !busAvail[1]);
  assert_retire_after_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busAvail[0]) |-> $past(errValid));
  assert_single_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dualBusCfg |-> !busAvail[1]);
endmodule

bind bus_cred_remap bcr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dualBusCfg(dualBusCfg), .threadReq(threadReq),
  .errValid(errValid), .grant(grant), .busSel(busSel), .busAvail(busAvail),
  .noBusFault(noBusFault)
);

// File: tb/bus_cred_remap_tb.sv
module bus_cred_remap_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dualBusCfg = 1'b1;
  logic [1:0] threadReq = '0;
  logic       errValid = 1'b0;
  logic       errThread = 1'b0;
  logic [1:0] grant, busSel, busAvail;
  logic       noBusFault;

  int vectors = 0;
  int misses  = 0;
  int credM[2];
  int mapM[2];
  int ptrM;

  always #2 clk = ~clk;

  bus_cred_remap u_dut (
    .clk(clk), .rst_n(rst_n), .dualBusCfg(dualBusCfg), .threadReq(threadReq),
    .errValid(errValid), .errThread(errThread), .grant(grant), .busSel(busSel),
    .busAvail(busAvail), .noBusFault(noBusFault)
  );

  task automatic doReset(input logic cfg);
    @(negedge clk);
    rst_n = 1'b0; dualBusCfg = cfg; threadReq = '0; errValid = 1'b0; errThread = 1'b0;
    repeat (2) @(negedge clk);
    credM[0] = 4; credM[1] = 4; mapM[0] = 0; mapM[1] = 1; ptrM = 0;
    rst_n = 1'b1;
  endtask

  // One vector: drive away from the edge, compare, then advance the model.
  task automatic step(input logic [1:0] req, input logic ev, input logic et, input string tag);
    logic av0, av1;
    logic [1:0] expG, expS, expA;
    logic expF;
    int s;
    @(negedge clk);
    threadReq = req; errValid = ev; errThread = et;
    #1;
    av0 = (credM[0] > 0);
    av1 = (credM[1] > 0) && dualBusCfg;
    expA = {av1, av0};
    expF = 1'b0; expG = 2'b00; expS = 2'b00;
    if (av0 && av1) begin
      expS = 2'b10; expG = req;
    end else if (av0 || av1) begin
      s = av1 ? 1 : 0;
      expS = {s[0], s[0]};
      if (req == 2'b11) expG = (ptrM == 1) ? 2'b10 : 2'b01;
      else expG = req;
    end else begin
      expF = 1'b1;
    end
    vectors++;
    if ({grant, busSel, busAvail, noBusFault} !== {expG, expS, expA, expF}) begin
      misses++;
      $display("FAIL %s: grant/busSel/busAvail/noBusFault got %b/%b/%b/%b expected %b/%b/%b/%b",
               tag, grant, busSel, busAvail, noBusFault, expG, expS, expA, expF);
    end
    if (ev) begin
      s = mapM[et];
      if (expA[s]) credM[s]--;
    end
    for (int t = 0; t < 2; t++) if (expG[t]) mapM[t] = expS[t];
    if ((av0 ^ av1) && expG != 2'b00) ptrM = expG[0] ? 1 : 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    doReset(1'b1);
    step(2'b00, 0, 0, "R1 reset state");
    step(2'b01, 0, 0, "R2 thread0 only");
    step(2'b10, 0, 0, "R2 thread1 only");
    step(2'b11, 0, 0, "R2 both threads split");
    // R5: thread1 stored on bus1, so bus1 drops to 3
    step(2'b00, 1, 1, "R5 blame bus1 via map");
    // R4: four errors on thread0 retire bus0
    for (int k = 0; k < 4; k++) step(2'b00, 1, 0, "R4 drain bus0");
    step(2'b00, 0, 0, "R4 bus0 retired");
    // R7: thread0 still mapped to retired bus0; ignored
    step(2'b00, 1, 0, "R7 error on retired bus ignored");
    // R5 clash: error with thread0's first grant on bus1 still blames bus0
    step(2'b01, 1, 0, "R5 clash error and remap");
    for (int k = 0; k < 5; k++) step(2'b11, 0, 0, "R6 alternate on bus1");
    step(2'b10, 0, 0, "R6 single request shared");
    step(2'b11, 0, 0, "R6 favour after single");
    // bus1 at 3: three errors retire it
    for (int k = 0; k < 2; k++) step(2'b00, 1, 1, "R4 drain bus1");
    step(2'b11, 0, 0, "R4 bus1 still live at 1");
    step(2'b00, 1, 0, "R4 last error bus1");
    step(2'b11, 0, 0, "R8 no bus, no grant");
    step(2'b01, 1, 1, "R8 error with no bus");
    step(2'b10, 0, 0, "R8 still faulted");

    doReset(1'b0);
    step(2'b00, 0, 0, "R1 reset single cfg");
    step(2'b11, 0, 0, "R3 single bus thread0 first");
    step(2'b11, 0, 0, "R3 single bus alternate");
    doReset(1'b0);
    step(2'b00, 1, 1, "R7 error on unfitted bus1 ignored");
    for (int k = 0; k < 3; k++) step(2'b10, 0, 0, "R3 thread1 on bus0");
    for (int k = 0; k < 4; k++) step(2'b00, 1, 1, "R4 thread1 drains bus0");
    step(2'b11, 0, 0, "R8 single cfg exhausted");
    step(2'b01, 0, 0, "R9 no grant when exhausted");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule